// File: doc/BRIEF.md
# T3/E3 Receive Performance Error Counters

This block keeps two saturating 16-bit error counts for the receive side of a T3/E3 framer. The first count tracks C-bit parity errors. For each M-frame, the three received CP bits are reduced by a 2-of-3 majority vote, and the result is compared with a parity bit that upstream logic has already computed over the frame's information bits. The second count changes meaning with the line mode. In T3 C-bit parity mode it counts M-frames whose three far-end block error bits are not all ones. In E3 mode it counts received remote alarm indication bits that arrive set. Frame alignment, overhead extraction and the parity calculation are done upstream, and their results arrive here as strobes and bits.

A snapshot strobe copies both live counts into readable holding registers and restarts the live counts in the same cycle, so no event falls between two intervals. A control input decides whether counting goes on while loss of frame is flagged. Software reads the holding registers through a small read port at fixed addresses.

Top module: `pmon_err_cnt`

## Requirements
- R1: After synchronous active-high reset, rd_data is 0, and reads of address 28h and 2Ah both return 0 until a snapshot has captured new events.
- R2: In T3 mode (mode_e3=0) with cbit_en=1, a cycle with mf_valid=1 counts one parity error when the majority of cp_rx[2:0] (at least two bits at 1 gives 1) differs from par_calc.
- R3: In T3 mode with cbit_en=1, a cycle with mf_valid=1 and febe_rx[2:0] not equal to 3'b111 counts one event in the second counter.
- R4: In E3 mode (mode_e3=1), a cycle with rai_valid=1 and rai_rx=1 counts one event in the second counter. mf_valid and febe_rx have no effect on that counter in this mode.
- R5: The parity counter never counts when mode_e3=1 or cbit_en=0. The second counter never counts in T3 mode when cbit_en=0. rai_valid has no effect in T3 mode.
- R6: While lof=1, both counters count only if lof_count_en=1. With lof_count_en=0 they hold.
- R7: Each live count saturates at FFFFh and does not wrap.
- R8: A cycle with snap=1 loads each holding register with its live count from before that cycle and sets the live count to 1 if an event arrives in that cycle, or to 0 if none does.
- R9: A read presents data on rd_data one cycle after rd_en=1. Address 28h returns the parity holding register and 2Ah returns the second holding register. Any other address, or a cycle without rd_en, returns 0 one cycle later. A read made in a snapshot cycle returns the value held before that snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_e3 | input | 1 | 1 selects E3 line mode, 0 selects T3 |
| cbit_en | input | 1 | T3 C-bit parity framing enabled |
| lof | input | 1 | Loss of frame flag |
| lof_count_en | input | 1 | 1 keeps both counters running during loss of frame |
| mf_valid | input | 1 | One-cycle strobe per received T3 M-frame |
| cp_rx | input | 3 | Received CP bits of the M-frame |
| par_calc | input | 1 | Parity computed over the M-frame information bits |
| febe_rx | input | 3 | Received far-end block error bits |
| rai_valid | input | 1 | Strobe marking a received E3 RAI bit |
| rai_rx | input | 1 | Received E3 RAI bit value |
| snap | input | 1 | Snapshot: copy live counts to holding registers and restart them |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that the mode and control inputs are ordinary synchronous levels, and that at most one event per counter arrives in a clock cycle. The read checks also assume that the read address is stable in the cycle it is strobed. The bench drives every input on the falling edge. It keeps the mode inputs fixed across blocks of random cycles, so each mode combination is exercised with loss of frame both on and off. It randomizes the strobes and overhead bits inside each block, and it adds directed cases for saturation, same-cycle snapshot events and unmapped reads.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_PAR = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_SEC = 8'h2A;
  localparam int unsigned NUM_CNT = 2;

  // 2-of-3 majority vote
  function automatic logic maj3(input logic [2:0] b);
    return (b[0] & b[1]) | (b[1] & b[2]) | (b[0] & b[2]);
  endfunction

  // saturating increment by one bit
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v, input logic inc);
    if (inc && (v != {CNT_W{1'b1}})) return v + 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pmon_event_decode.sv
module pmon_event_decode
  import pmon_pkg::*;
(
  input  logic       mode_e3,
  input  logic       cbit_en,
  input  logic       lof,
  input  logic       lof_count_en,
  input  logic       mf_valid,
  input  logic [2:0] cp_rx,
  input  logic       par_calc,
  input  logic [2:0] febe_rx,
  input  logic       rai_valid,
  input  logic       rai_rx,
  output logic       par_evt,
  output logic       sec_evt
);
  logic gate_ok;
  logic t3_cbit;
  logic cp_mismatch;
  logic febe_bad;
  logic rai_set;

  always_comb begin
    gate_ok     = ~lof | lof_count_en;
    t3_cbit     = ~mode_e3 & cbit_en;
    cp_mismatch = maj3(cp_rx) ^ par_calc;
    febe_bad    = (febe_rx != 3'b111);
    rai_set     = rai_valid & rai_rx;
    par_evt     = gate_ok & t3_cbit & mf_valid & cp_mismatch;
    if (mode_e3) sec_evt = gate_ok & rai_set;
    else         sec_evt = gate_ok & t3_cbit & mf_valid & febe_bad;
  end
endmodule

// File: rtl/pmon_sat_counter.sv
module pmon_sat_counter
  import pmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             snap,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else if (snap) begin
      held <= live;
      live <= {{(CNT_W-1){1'b0}}, evt};
    end else begin
      live <= sat_add(live, evt);
    end
  end
endmodule

// File: rtl/pmon_regport.sv
module pmon_regport
  import pmon_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] held,
  output logic [CNT_W-1:0]           rd_data
);
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_en) begin
      unique case (rd_addr)
        ADDR_PAR: rd_mux = held[0];
        ADDR_SEC: rd_mux = held[1];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pmon_err_cnt.sv
module pmon_err_cnt
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_e3,
  input  logic              cbit_en,
  input  logic              lof,
  input  logic              lof_count_en,
  input  logic              mf_valid,
  input  logic [2:0]        cp_rx,
  input  logic              par_calc,
  input  logic [2:0]        febe_rx,
  input  logic              rai_valid,
  input  logic              rai_rx,
  input  logic              snap,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic par_evt;
  logic sec_evt;
  logic [NUM_CNT-1:0]            evt_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] live_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] held_q;

  pmon_event_decode u_dec (
    .mode_e3(mode_e3), .cbit_en(cbit_en), .lof(lof), .lof_count_en(lof_count_en),
    .mf_valid(mf_valid), .cp_rx(cp_rx), .par_calc(par_calc), .febe_rx(febe_rx),
    .rai_valid(rai_valid), .rai_rx(rai_rx), .par_evt(par_evt), .sec_evt(sec_evt)
  );

  assign evt_vec = {sec_evt, par_evt};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmon_sat_counter u_cnt (
      .clk(clk), .rst(rst), .evt(evt_vec[i]), .snap(snap),
      .live(live_q[i]), .held(held_q[i])
    );
  end

  pmon_regport u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .held(held_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/pmon_err_cnt_chk.sv
module pmon_err_cnt_chk
  import pmon_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode_e3,
  input logic              cbit_en,
  input logic              lof,
  input logic              lof_count_en,
  input logic              snap,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  rd_data,
  input logic              par_evt,
  input logic              sec_evt,
  input logic [CNT_W-1:0]  live_par,
  input logic [CNT_W-1:0]  held_par
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  AST_PAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!snap && par_evt && live_par != MAXV) |=> live_par == $past(live_par) + 1'b1); // R2
  AST_PAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!snap && !par_evt) |=> $stable(live_par)); // R2
  AST_NO_PAR_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_e3 || !cbit_en) |-> !par_evt); // R5
  AST_LOF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lof && !lof_count_en) |-> (!par_evt && !sec_evt)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!snap && live_par == MAXV) |=> live_par == MAXV); // R7
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
    snap |=> held_par == $past(live_par)); // R8
  AST_SNAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    snap |=> live_par == {{(CNT_W-1){1'b0}}, $past(par_evt)}); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || (rd_addr != ADDR_PAR && rd_addr != ADDR_SEC)) |=> rd_data == '0); // R9
  AST_RD_PAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_PAR) |=> rd_data == $past(held_par)); // R9
endmodule

bind pmon_err_cnt pmon_err_cnt_chk u_chk (
  .clk(clk), .rst(rst), .mode_e3(mode_e3), .cbit_en(cbit_en), .lof(lof),
  .lof_count_en(lof_count_en), .snap(snap), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .par_evt(par_evt), .sec_evt(sec_evt),
  .live_par(live_q[0]), .held_par(held_q[0])
);

// File: tb/pmon_err_cnt_bench.sv
module pmon_err_cnt_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_e3 = 0, cbit_en = 0, lof = 0, lof_count_en = 0;
  logic mf_valid = 0, par_calc = 0, rai_valid = 0, rai_rx = 0, snap = 0, rd_en = 0;
  logic [2:0] cp_rx = 0, febe_rx = 3'b111;
  logic [7:0] rd_addr = 0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  int unsigned m_par = 0, m_sec = 0, h_par = 0, h_sec = 0;

  always #5 clk = ~clk;

  pmon_err_cnt u_pmon_err_cnt (.*);

  // independent model of event conditions
  function automatic bit exp_par_ev();
    int ones = cp_rx[0] + cp_rx[1] + cp_rx[2];
    bit vote = (ones > 1);
    if (lof && !lof_count_en) return 0;
    if (mode_e3 || !cbit_en || !mf_valid) return 0;
    return vote != par_calc;
  endfunction

  function automatic bit exp_sec_ev();
    if (lof && !lof_count_en) return 0;
    if (mode_e3) return rai_valid && rai_rx;
    if (!cbit_en || !mf_valid) return 0;
    return !(febe_rx[0] && febe_rx[1] && febe_rx[2]);
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: model follows the inputs present at this edge
  task automatic step();
    bit pe = exp_par_ev();
    bit se = exp_sec_ev();
    @(posedge clk);
    cyc++;
    if (!rst) begin
      if (snap) begin
        h_par = m_par; h_sec = m_sec;
        m_par = pe; m_sec = se;
      end else begin
        if (pe && m_par < 32'hFFFF) m_par++;
        if (se && m_sec < 32'hFFFF) m_sec++;
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    mf_valid = 0; rai_valid = 0; snap = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int unsigned exp, input string req);
    quiet();
    rd_en = 1; rd_addr = a;
    step();
    rd_en = 0;
    check(req, rd_data, exp);
  endtask

  task automatic do_snap();
    quiet(); snap = 1; step(); snap = 0;
  endtask

  task automatic snap_and_read(input string req);
    do_snap();
    rd(8'h28, h_par, req);
    rd(8'h2A, h_sec, req);
  endtask

  task automatic rand_block(input bit e3, input bit cb, input bit lf, input bit lce, input int n);
    mode_e3 = e3; cbit_en = cb; lof = lf; lof_count_en = lce;
    for (int i = 0; i < n; i++) begin
      mf_valid  = $urandom_range(0, 1);
      cp_rx     = $urandom_range(0, 7);
      par_calc  = $urandom_range(0, 1);
      febe_rx   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 7) : 3'b111;
      rai_valid = $urandom_range(0, 1);
      rai_rx    = $urandom_range(0, 1);
      snap      = ($urandom_range(0, 40) == 0);
      rd_en     = 0;
      step();
    end
    quiet();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cyc > 190000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(); step();
    // R1 reset state
    check("R1 rd_data after reset", rd_data, 0);
    rst = 0;
    rd(8'h28, 0, "R1 par reg after reset");
    rd(8'h2A, 0, "R1 sec reg after reset");

    // R2 directed: cp=110 (vote 1) vs par 0 -> error; cp=001 (vote 0) vs par 0 -> none
    mode_e3 = 0; cbit_en = 1; lof = 0; lof_count_en = 0;
    mf_valid = 1; febe_rx = 3'b111; par_calc = 0;
    cp_rx = 3'b110; step();
    cp_rx = 3'b001; step();
    cp_rx = 3'b101; par_calc = 1; step();
    cp_rx = 3'b010; par_calc = 1; step();
    snap_and_read("R2 majority parity");
    check("R2 directed count", h_par, 2);

    // R3 directed FEBE
    mf_valid = 1; cp_rx = 0; par_calc = 0;
    febe_rx = 3'b011; step();
    febe_rx = 3'b111; step();
    febe_rx = 3'b000; step();
    snap_and_read("R3 febe count");
    check("R3 directed count", h_sec, 2);

    // R4 directed E3 RAI, mf/febe ignored
    mode_e3 = 1; mf_valid = 1; febe_rx = 0;
    rai_valid = 1; rai_rx = 1; step();
    rai_valid = 1; rai_rx = 0; step();
    rai_valid = 0; rai_rx = 1; step();
    snap_and_read("R4 rai count");
    check("R4 directed count", h_sec, 1);
    check("R5 e3 parity idle", h_par, 0);

    // R5 T3 without C-bit: nothing counts
    mode_e3 = 0; cbit_en = 0; mf_valid = 1; cp_rx = 3'b111; par_calc = 0;
    febe_rx = 0; rai_valid = 1; rai_rx = 1; step(); step();
    snap_and_read("R5 no cbit");
    check("R5 no cbit par", h_par, 0);
    check("R5 no cbit sec", h_sec, 0);

    // R6 LOF gating
    cbit_en = 1; lof = 1; lof_count_en = 0; mf_valid = 1; febe_rx = 0; cp_rx = 3'b111; par_calc = 0;
    step(); step();
    lof_count_en = 1; step();
    snap_and_read("R6 lof gating");
    check("R6 par during lof", h_par, 1);
    check("R6 sec during lof", h_sec, 1);
    lof = 0;

    // R8 same-cycle event on snap
    mf_valid = 1; febe_rx = 0; cp_rx = 3'b111; par_calc = 0; step();
    snap = 1; step(); snap = 0; quiet();
    check("R8 held before snap", h_par, 1);
    snap_and_read("R8 event in snap cycle");
    check("R8 new interval par", h_par, 1);
    check("R8 new interval sec", h_sec, 1);

    // R9 unmapped addresses and read during snap
    rd(8'h29, 0, "R9 unmapped 29h");
    rd(8'h00, 0, "R9 unmapped 00h");
    rd(8'hAA, 0, "R9 unmapped AAh");
    quiet(); rd_en = 1; rd_addr = 8'h28; snap = 1; step(); quiet();
    check("R9 read in snap cycle", rd_data, 1);
    step();
    check("R9 no read gives zero", rd_data, 0);

    // random blocks over mode combinations
    for (int k = 0; k < 16; k++) begin
      rand_block(k[0], k[1], k[2], k[3], 400);
      snap_and_read("R2 R3 R4 R5 R6 random");
    end

    // R7 saturation
    mode_e3 = 0; cbit_en = 1; lof = 0; mf_valid = 1; cp_rx = 3'b111; par_calc = 0; febe_rx = 3'b111;
    for (int i = 0; i < 65545; i++) step();
    snap_and_read("R7 saturation");
    check("R7 saturated value", h_par, 16'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule